// File: doc/BRIEF.md
# Hardware-Triggered Four-Channel Scan Sequencer

This block controls an external successive-approximation converter. It makes the converter scan four neighbouring analog channels, and each scan is launched by a single-cycle hardware trigger. Software drives the block through two write strobes.

- A control write carries an enable bit and a start bit. Together they place the block in one of three levels:
  - stopped,
  - idle but not armed,
  - idle and armed for triggers.
- A channel write picks the first channel of the scan.

The block talks to the converter through a handshake. It sends a start strobe, an abort strobe and a channel number. It gets back a done pulse and a result word. Each accepted result is held in a result register and announced by a one-cycle interrupt pulse.

Once a scan is under way, three events abandon the conversion in flight and start the scan again from its first channel:

- a new trigger;
- a channel write;
- a control write that sets start.

A control write that clears start abandons the conversion and leaves the block idle. The required settling time after enabling is left to software.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the block is stopped and disarmed, `result` is 0 and `irq`, `conv_start` and `conv_abort` are 0. A control write with `ctrl_en`=1 and `ctrl_start`=0 makes the block idle. In that state no conversion begins.
- R2: A control write with `ctrl_en`=1 and `ctrl_start`=1 arms the block without starting any conversion.
- R3: `hw_trig` seen while armed (start already 1 before the cycle) asserts `conv_start` in that same cycle, with `conv_chan` equal to the first channel. `hw_trig` while stopped or not armed is ignored.
- R4: Each accepted `conv_done` loads `conv_result` into `result` and pulses `irq` high for one cycle, both visible one cycle later.
- R5: A scan converts channels F, F+1, F+2 and F+3. The next `conv_start` is issued in the same cycle as the accepted done. After the fourth done the block is idle and still armed, so one trigger yields exactly four `irq` pulses.
- R6: `hw_trig` during a conversion asserts `conv_abort` and `conv_start` in the same cycle and restarts at the first channel. A `conv_done` in that cycle is discarded (no `irq`).
- R7: A channel write during a conversion aborts it and restarts the scan at the newly written channel.
- R8: A control write setting start during a conversion aborts it and restarts the scan at the first channel.
- R9: A control write with start 0 during a conversion asserts `conv_abort` without `conv_start`. The block then ignores triggers: it is idle when `ctrl_en`=1 and stopped when `ctrl_en`=0.
- R10: The first-channel field is 3 bits wide. Written values above 4 are clamped to 4, so the highest converted channel is 7.
- R11: `conv_done` arriving while no conversion is active changes neither `result` nor `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_en | input | 1 | Enable value written by the control write |
| ctrl_start | input | 1 | Start value written by the control write |
| chan_wr | input | 1 | First-channel write strobe |
| chan_val | input | 3 | First-channel value (clamped to 4) |
| hw_trig | input | 1 | Single-cycle hardware trigger |
| conv_start | output | 1 | Converter start strobe |
| conv_abort | output | 1 | Converter abort strobe |
| conv_chan | output | 3 | Channel for the conversion being started |
| conv_done | input | 1 | Converter done pulse |
| conv_result | input | 12 | Converter result word |
| result | output | 12 | Last accepted conversion result |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The sharpest same-cycle collision is between a converter done pulse and an abort event: a trigger, a channel write or a start write. The abort must win, and the result must be dropped. The bench forces a done pulse in the very cycle it pulses the trigger. It also times a channel write and a clear-start write onto the natural done cycle of the converter stub. It then judges the outcome by the absence of an `irq` in the following cycle and by an unchanged `result`, both compared against a behavioural model every clock.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
    typedef enum logic [1:0] {
        PH_STOP = 2'd0,
        PH_IDLE = 2'd1,
        PH_CONV = 2'd2
    } phase_e;
endpackage

// File: rtl/adc_scan_clamp.sv
module adc_scan_clamp #(
    parameter int CH_W      = 3,
    parameter int MAX_FIRST = 4
) (
    input  logic [CH_W-1:0] raw,
    output logic [CH_W-1:0] clamped
);
    localparam logic [CH_W-1:0] LIM = CH_W'(MAX_FIRST);

    always_comb begin
        clamped = (raw > LIM) ? LIM : raw;
    end
endmodule

// File: rtl/adc_scan_fsm.sv
module adc_scan_fsm
    import adc_scan_pkg::*;
#(
    parameter int CH_W      = 3,
    parameter int SCAN_LEN  = 4,
    parameter int MAX_FIRST = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_wr,
    input  logic            ctrl_en,
    input  logic            ctrl_start,
    input  logic            chan_wr,
    input  logic [CH_W-1:0] chan_clamped,
    input  logic            hw_trig,
    input  logic            conv_done,
    output logic            conv_start,
    output logic            conv_abort,
    output logic [CH_W-1:0] conv_chan,
    output logic            accept
);
    localparam int IDX_W = (SCAN_LEN > 1) ? $clog2(SCAN_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SCAN_LEN - 1);

    typedef struct packed {
        phase_e            phase;
        logic              start;
        logic [CH_W-1:0]   first;
        logic [CH_W-1:0]   cur;
        logic [IDX_W-1:0]  idx;
    } seq_t;

    seq_t s_q, s_d;
    logic set_start, clr_start;

    always_comb begin
        s_d        = s_q;
        conv_start = 1'b0;
        conv_abort = 1'b0;
        accept     = 1'b0;
        set_start  = ctrl_wr & ctrl_en & ctrl_start;
        clr_start  = ctrl_wr & ~(ctrl_en & ctrl_start);

        if (chan_wr) begin
            s_d.first = chan_clamped;
        end
        if (ctrl_wr) begin
            s_d.start = ctrl_en & ctrl_start;
        end

        unique case (s_q.phase)
            PH_STOP: begin
                if (ctrl_wr && ctrl_en) begin
                    s_d.phase = PH_IDLE;
                end
            end
            PH_IDLE: begin
                if (ctrl_wr && !ctrl_en) begin
                    s_d.phase = PH_STOP;
                end else if (hw_trig && s_q.start && !clr_start) begin
                    conv_start = 1'b1;
                    s_d.phase  = PH_CONV;
                    s_d.idx    = '0;
                    s_d.cur    = s_d.first;
                end
            end
            PH_CONV: begin
                if (clr_start) begin
                    conv_abort = 1'b1;
                    s_d.phase  = ctrl_en ? PH_IDLE : PH_STOP;
                end else if (hw_trig || chan_wr || set_start) begin
                    conv_abort = 1'b1;
                    conv_start = 1'b1;
                    s_d.idx    = '0;
                    s_d.cur    = s_d.first;
                end else if (conv_done) begin
                    accept = 1'b1;
                    if (s_q.idx == LAST) begin
                        s_d.phase = PH_IDLE;
                    end else begin
                        conv_start = 1'b1;
                        s_d.idx    = s_q.idx + IDX_W'(1);
                        s_d.cur    = s_q.cur + CH_W'(1);
                    end
                end
            end
            default: s_d.phase = PH_STOP;
        endcase

        conv_chan = s_d.cur;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_STOP, start: 1'b0, first: '0, cur: '0, idx: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assert_stop_disarmed_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_STOP) |-> !s_q.start);

    assert_start_needs_arm_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> s_q.start);

    assert_scan_end_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_CONV && conv_done && !conv_abort && s_q.idx == LAST)
        |=> (s_q.phase == PH_IDLE && s_q.start));

    assert_abort_only_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_abort |-> (s_q.phase == PH_CONV));

    assert_clear_start_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_CONV && ctrl_wr && !(ctrl_en && ctrl_start))
        |-> (conv_abort && !conv_start));

    assert_first_in_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.first <= CH_W'(MAX_FIRST));
endmodule

// File: rtl/adc_scan_result.sv
module adc_scan_result #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [RES_W-1:0] data,
    output logic [RES_W-1:0] result,
    output logic             irq
);
    typedef struct packed {
        logic [RES_W-1:0] res;
        logic             irq;
    } out_t;

    out_t o_q, o_d;

    always_comb begin
        o_d.res = accept ? data : o_q.res;
        o_d.irq = accept;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign result = o_q.res;
    assign irq    = o_q.irq;
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
    parameter int CH_W     = 3,
    parameter int SCAN_LEN = 4,
    parameter int RES_W    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             ctrl_en,
    input  logic             ctrl_start,
    input  logic             chan_wr,
    input  logic [CH_W-1:0]  chan_val,
    input  logic             hw_trig,
    output logic             conv_start,
    output logic             conv_abort,
    output logic [CH_W-1:0]  conv_chan,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    output logic [RES_W-1:0] result,
    output logic             irq
);
    localparam int MAX_FIRST = (1 << CH_W) - SCAN_LEN;

    logic [CH_W-1:0] chan_clamped;
    logic            accept;

    adc_scan_clamp #(.CH_W(CH_W), .MAX_FIRST(MAX_FIRST)) u_clamp (
        .raw     (chan_val),
        .clamped (chan_clamped)
    );

    adc_scan_fsm #(.CH_W(CH_W), .SCAN_LEN(SCAN_LEN), .MAX_FIRST(MAX_FIRST)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_wr      (ctrl_wr),
        .ctrl_en      (ctrl_en),
        .ctrl_start   (ctrl_start),
        .chan_wr      (chan_wr),
        .chan_clamped (chan_clamped),
        .hw_trig      (hw_trig),
        .conv_done    (conv_done),
        .conv_start   (conv_start),
        .conv_abort   (conv_abort),
        .conv_chan    (conv_chan),
        .accept       (accept)
    );

    adc_scan_result #(.RES_W(RES_W)) u_result (
        .clk    (clk),
        .rst_n  (rst_n),
        .accept (accept),
        .data   (conv_result),
        .result (result),
        .irq    (irq)
    );

    assert_irq_follows_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(conv_done));

    assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> $stable(result));
endmodule

// File: tb/test_adc_scan_seq.sv
`timescale 1ns/1ps
module test_adc_scan_seq;
    localparam int CH_W  = 3;
    localparam int RES_W = 12;
    localparam int LAT   = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_wr = 0, ctrl_en = 0, ctrl_start = 0, chan_wr = 0, hw_trig = 0;
    logic [CH_W-1:0] chan_val = '0;
    logic conv_done = 0;
    logic [RES_W-1:0] conv_result = '0;
    logic conv_start, conv_abort, irq;
    logic [CH_W-1:0] conv_chan;
    logic [RES_W-1:0] result;

    always #5 clk = ~clk;

    adc_scan_seq i_adc_scan_seq (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en),
        .ctrl_start(ctrl_start), .chan_wr(chan_wr), .chan_val(chan_val),
        .hw_trig(hw_trig), .conv_start(conv_start), .conv_abort(conv_abort),
        .conv_chan(conv_chan), .conv_done(conv_done), .conv_result(conv_result),
        .result(result), .irq(irq)
    );

    int n_tests = 0, n_fail = 0, n_irq = 0, cyc = 0;
    int chq[$];
    logic force_done = 0;
    bit finished = 0;

    // behavioural reference state: phase 0 stopped, 1 idle, 2 converting
    int m_phase = 0, m_first = 0, m_idx = 0, m_cur = 0, m_res = 0;
    bit m_start = 0, m_irq = 0;
    int n_phase, n_first, n_idx, n_cur;
    bit n_start, e_start, e_abort, e_acc;
    int e_chan;

    // converter stub
    bit st_busy = 0;
    int st_cnt = 0, st_ch = 0, serial = 0;
    bit s_start, s_abort;
    int s_chan;

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic model_eval();
        bit clr, set;
        clr = ctrl_wr && !(ctrl_en && ctrl_start);
        set = ctrl_wr && ctrl_en && ctrl_start;
        n_first = chan_wr ? ((int'(chan_val) > 4) ? 4 : int'(chan_val)) : m_first;
        n_start = ctrl_wr ? (ctrl_en && ctrl_start) : m_start;
        n_phase = m_phase; n_idx = m_idx; n_cur = m_cur;
        e_start = 0; e_abort = 0; e_acc = 0;
        if (m_phase == 0) begin
            if (ctrl_wr && ctrl_en) n_phase = 1;
        end else if (m_phase == 1) begin
            if (ctrl_wr && !ctrl_en) n_phase = 0;
            else if (hw_trig && m_start && !clr) begin
                e_start = 1; n_phase = 2; n_idx = 0; n_cur = n_first;
            end
        end else begin
            if (clr) begin
                e_abort = 1; n_phase = ctrl_en ? 1 : 0;
            end else if (hw_trig || chan_wr || set) begin
                e_abort = 1; e_start = 1; n_idx = 0; n_cur = n_first;
            end else if (conv_done) begin
                e_acc = 1;
                if (m_idx == 3) n_phase = 1;
                else begin
                    e_start = 1; n_idx = m_idx + 1; n_cur = m_cur + 1;
                end
            end
        end
        e_chan = n_cur;
    endtask

    task automatic tick();
        conv_done   = (st_busy && st_cnt == 0) || force_done;
        conv_result = RES_W'((st_ch << 8) | (serial & 255));
        #4;
        model_eval();
        chk("R3 conv_start", int'(conv_start), int'(e_start));
        chk("R6 conv_abort", int'(conv_abort), int'(e_abort));
        if (e_start) chk("R5 conv_chan", int'(conv_chan), e_chan);
        chk("R4 irq", int'(irq), int'(m_irq));
        chk("R4 result", int'(result), m_res);
        if (irq) n_irq++;
        if (conv_start) chq.push_back(int'(conv_chan));
        s_start = conv_start; s_abort = conv_abort; s_chan = int'(conv_chan);
        @(posedge clk);
        m_irq = e_acc;
        if (e_acc) m_res = int'(conv_result);
        m_phase = n_phase; m_first = n_first; m_idx = n_idx; m_cur = n_cur; m_start = n_start;
        if (st_busy && st_cnt == 0) serial++;
        if (s_start) begin
            st_busy = 1; st_cnt = LAT; st_ch = s_chan;
        end else if (s_abort) begin
            st_busy = 0;
        end else if (st_busy) begin
            if (st_cnt == 0) st_busy = 0;
            else st_cnt--;
        end
        #1;
        ctrl_wr = 0; chan_wr = 0; hw_trig = 0; force_done = 0;
        @(negedge clk);
        cyc++;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr_ctrl(bit en, bit st);
        ctrl_wr = 1; ctrl_en = en; ctrl_start = st;
        tick();
    endtask

    task automatic wr_chan(int v);
        chan_wr = 1; chan_val = CH_W'(v);
        tick();
    endtask

    task automatic trig();
        hw_trig = 1;
        tick();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_500_000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int b;
        repeat (3) @(negedge clk);
        chk("R1 reset irq", int'(irq), 0);
        chk("R1 reset result", int'(result), 0);
        chk("R1 reset conv_start", int'(conv_start), 0);
        chk("R1 reset conv_abort", int'(conv_abort), 0);
        rst_n = 1;
        run(2);

        // R1: enable only -> idle, no conversion
        wr_ctrl(1, 0);
        run(4);
        chk("R1 no conversion in idle", chq.size(), 0);
        // R3: trigger ignored while not armed
        trig(); run(3);
        chk("R3 trigger ignored unarmed", chq.size(), 0);

        // R2: arming starts nothing
        wr_ctrl(1, 1);
        run(5);
        chk("R2 arming starts nothing", chq.size(), 0);

        // R5: full scan from channel 0
        n_irq = 0; chq.delete();
        trig(); run(30);
        chk("R5 four irqs per scan", n_irq, 4);
        chk("R5 scan length", chq.size(), 4);
        for (int i = 0; i < 4 && i < chq.size(); i++) chk("R5 channel order", chq[i], i);
        n_irq = 0;
        trig(); run(30);
        chk("R5 still armed after scan", n_irq, 4);

        // R10: clamp
        wr_chan(7);
        chq.delete();
        trig(); run(30);
        chk("R10 clamped first channel", (chq.size() > 0) ? chq[0] : -1, 4);
        chk("R10 highest channel", (chq.size() > 3) ? chq[3] : -1, 7);

        // R6: retrigger mid-scan
        wr_chan(1);
        trig(); run(6);
        chq.delete();
        trig();
        chk("R6 restart at first", (chq.size() > 0) ? chq[0] : -1, 1);
        run(30);

        // R6: done and trigger in the same cycle
        trig(); run(2);
        b = n_irq;
        force_done = 1; hw_trig = 1; tick();
        tick();
        chk("R6 colliding done discarded", n_irq, b);
        run(30);

        // R7: channel write mid-conversion
        trig(); run(3);
        chq.delete();
        wr_chan(3);
        chk("R7 restart at new channel", (chq.size() > 0) ? chq[0] : -1, 3);
        run(30);

        // R8: start rewrite mid-conversion
        trig(); run(6);
        chq.delete();
        wr_ctrl(1, 1);
        chk("R8 restart at first", (chq.size() > 0) ? chq[0] : -1, 3);
        run(30);

        // R9: clear start mid-conversion
        trig(); run(3);
        b = n_irq;
        wr_ctrl(1, 0);
        run(30);
        chk("R9 no results after clear", n_irq, b);
        chq.delete();
        trig(); run(3);
        chk("R9 idle ignores trigger", chq.size(), 0);

        // R9: clear enable mid-conversion -> stopped
        wr_ctrl(1, 1);
        trig(); run(3);
        wr_ctrl(0, 1);
        run(20);
        chq.delete();
        trig(); run(3);
        chk("R9 stopped ignores trigger", chq.size(), 0);
        wr_ctrl(1, 1);
        trig();
        chk("R9 re-enable works", chq.size(), 1);
        run(30);

        // R11: stray done while idle
        b = n_irq;
        force_done = 1; tick();
        tick();
        chk("R11 stray done ignored", n_irq, b);
        run(3);

        finish_run();
    end
endmodule